// File: doc/BRIEF.md
# Wide FIFO Diagnostic Access Port

This block is a test-access wrapper for a display data FIFO whose entries are twice as wide as the software register that reaches them. Test software sees one 32-bit data register that it can read and write. Two consecutive writes are packed into one 64-bit entry. The entry is committed, and the write pointer moves, only when the second half arrives.

Reading works through a 64-bit output latch. The first read after the FIFO has been filled is a dummy access. Its returned data has no meaning; it only moves the oldest entry into the latch. Every later read returns the low half of the latch and then starts an internal shift. The shift exposes the high half, or it reloads the latch from the next entry and advances the read pointer. Because the shift completes a few clocks after the read, reads must be spaced. A read that arrives too early sees the old latch contents and sets a sticky flag. Access in both directions is qualified by two configuration inputs: a diagnostic enable, and the load enable of the normal fetch path.

Top module: `wideFifoDiagPort`

## Requirements
- R1: A write or read is accepted only while `diagEn` is 1 and `fetchLoadEn` is 0. At any other time it changes no pointer, no pending half, no latch contents and no flag.
- R2: Within an entry, the first accepted write supplies bits 31:0 and the second supplies bits 63:32. The entry is stored, and the write pointer advances by one, on the second write only.
- R3: While `DEPTH` entries are stored, `fifoFull` is 1. A completing second write at that time is discarded, and the stored entries are unchanged.
- R4: After reset, or after the FIFO has run dry, the first accepted read is a priming read. Its data is don't-care, and it loads the oldest entry into the output latch.
- R5: Once the latch is primed, read data is combinational from the latch. Reads return the low half and then the high half of each entry, in write order. The read pointer advances by one entry per two reads, at the reload.
- R6: A read is accepted for the FIFO only if at least `SPACING` (default 4) clocks have passed since the previous accepted read. An earlier read returns the unchanged latch value, causes no shift and no pointer move, and sets `spacingErr`, which stays 1 until reset.
- R7: `fifoEmpty` is 1 when no committed entry waits in the FIFO. A reload attempted while the FIFO is empty leaves the latch unprimed, so the next read is a priming read again.
- R8: After reset, `fifoEmpty` is 1, `fifoFull` is 0 and `spacingErr` is 0. The data register and the latch have no defined reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| diagEn | input | 1 | Diagnostic access enable |
| fetchLoadEn | input | 1 | Normal fetch load enable; blocks diagnostic access when 1 |
| busWr | input | 1 | Write strobe for the data register, one clock per access |
| busRd | input | 1 | Read strobe for the data register, one clock per access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, low word of the output latch |
| fifoFull | output | 1 | FIFO holds `DEPTH` entries |
| fifoEmpty | output | 1 | FIFO holds no entry |
| spacingErr | output | 1 | Sticky flag: a read came before the spacing window had elapsed |

## Verification
Several rules are checked by assertions on every cycle. Gated accesses must leave the write pointer and the half-select still. A write into a full FIFO must not move the pointer. A reload from an empty FIFO must not move the read pointer and must drop the primed state. The error flag must stay set once set, the latch must hold whenever no load or shift is ordered, and the pointer distance must never exceed the depth.

Other behaviour can only be shown by the bench's scenarios against its reference queue. This covers the low-then-high ordering, write order across many entries, the don't-care priming read and its return after the FIFO drains, the discarded extra entry when full, and the stale data returned by a read that comes too early.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
  // Strobes from control to datapath, at most one latch action per cycle
  typedef struct packed {
    logic wrLow;      // capture low word into staging
    logic wrEntry;    // commit {busWdata, staging} into FIFO
    logic loadLatch;  // load output latch from FIFO head
    logic shiftLatch; // move latch high word into low word
  } dpStrobe_t;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } rdOp_t;
endpackage

// File: rtl/wfdCtrl.sv
module wfdCtrl
  import wfd_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int SPACING = 4,
  localparam int AW     = $clog2(DEPTH),
  localparam int GW     = $clog2(SPACING)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            diagEn,
  input  logic            fetchLoadEn,
  input  logic            busWr,
  input  logic            busRd,
  output dpStrobe_t       strobe,
  output logic [AW-1:0]   wrAddr,
  output logic [AW-1:0]   rdAddr,
  output logic            fifoFull,
  output logic            fifoEmpty,
  output logic            spacingErr
);
  logic          accessOk, wrReq, rdReq;
  logic [AW:0]   wrPtr, rdPtr;
  logic          wrHalf, rdHalf, primed;
  logic [GW-1:0] gap;
  rdOp_t         pendOp;
  logic          execNow;

  assign accessOk  = diagEn & ~fetchLoadEn;
  assign wrReq     = busWr & accessOk;
  assign rdReq     = busRd & accessOk;
  assign fifoEmpty = (wrPtr == rdPtr);
  assign fifoFull  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign wrAddr    = wrPtr[AW-1:0];
  assign rdAddr    = rdPtr[AW-1:0];
  assign execNow   = (gap == GW'(1));

  always_comb begin
    strobe            = '0;
    strobe.wrLow      = wrReq & ~wrHalf;
    strobe.wrEntry    = wrReq & wrHalf & ~fifoFull;
    strobe.shiftLatch = execNow && (pendOp == OP_SHIFT);
    strobe.loadLatch  = execNow && (pendOp == OP_LOAD) && !fifoEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      wrHalf     <= 1'b0;
      rdHalf     <= 1'b0;
      primed     <= 1'b0;
      gap        <= '0;
      pendOp     <= OP_NONE;
      spacingErr <= 1'b0;
    end else begin
      if (wrReq) wrHalf <= ~wrHalf;
      if (strobe.wrEntry) wrPtr <= wrPtr + 1'b1;
      if (gap != '0) gap <= gap - 1'b1;
      if (execNow) begin
        pendOp <= OP_NONE;
        if (pendOp == OP_SHIFT) begin
          rdHalf <= 1'b1;
        end else if (pendOp == OP_LOAD) begin
          if (!fifoEmpty) begin
            rdPtr  <= rdPtr + 1'b1;
            primed <= 1'b1;
            rdHalf <= 1'b0;
          end else begin
            primed <= 1'b0;
          end
        end
      end
      if (rdReq) begin
        if (gap != '0) begin
          spacingErr <= 1'b1;
        end else begin
          gap    <= GW'(SPACING - 1);
          pendOp <= (primed && !rdHalf) ? OP_SHIFT : OP_LOAD;
        end
      end
    end
  end

  // R1: gated accesses leave write side untouched
  assert_gated_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    !accessOk |=> $stable(wrPtr) && $stable(wrHalf));
  // R3: no commit past a full FIFO
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrHalf && fifoFull) |=> $stable(wrPtr));
  // R3: pointer distance bounded by depth
  assert_occupancy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr - rdPtr) <= (AW+1)'(DEPTH));
  // R7: reload from empty FIFO drops primed state, pointer still
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (execNow && pendOp == OP_LOAD && fifoEmpty) |=> $stable(rdPtr) && !primed);
  // R6: early read flags error, flag is sticky
  assert_early_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && gap != '0) |=> spacingErr);
  assert_sticky_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    spacingErr |=> spacingErr);
endmodule

// File: rtl/wfdData.sv
module wfdData
  import wfd_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int EW    = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata
);
  logic [EW-1:0]     entryMem [DEPTH];
  logic [WORD_W-1:0] lowStage;
  logic [EW-1:0]     outLatch;

  // Storage has no reset: register contents are undefined after reset (R8)
  always_ff @(posedge clk) begin
    if (strobe.wrLow)   lowStage <= busWdata;
    if (strobe.wrEntry) entryMem[wrAddr] <= {busWdata, lowStage};
    if (strobe.loadLatch)
      outLatch <= entryMem[rdAddr];
    else if (strobe.shiftLatch)
      outLatch[WORD_W-1:0] <= outLatch[EW-1:WORD_W];
  end

  assign busRdata = outLatch[WORD_W-1:0];

  // R5: load and shift never ordered together
  assert_one_latch_op_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadLatch, strobe.shiftLatch}));
  // R6: latch holds whenever no action is ordered
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadLatch || strobe.shiftLatch) |=> $stable(busRdata));
endmodule

// File: rtl/wideFifoDiagPort.sv
module wideFifoDiagPort
  import wfd_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int SPACING = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        diagEn,
  input  logic        fetchLoadEn,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        fifoFull,
  output logic        fifoEmpty,
  output logic        spacingErr
);
  localparam int AW = $clog2(DEPTH);

  dpStrobe_t     strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  wfdCtrl #(.DEPTH(DEPTH), .SPACING(SPACING)) u_ctrl (
    .clk(clk), .rstN(rstN), .diagEn(diagEn), .fetchLoadEn(fetchLoadEn),
    .busWr(busWr), .busRd(busRd), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .spacingErr(spacingErr)
  );

  wfdData #(.WORD_W(32), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );
endmodule

// File: tb/test_wideFifoDiagPort.sv
module test_wideFifoDiagPort;
  localparam int DEPTH   = 16;
  localparam int SPACING = 4;

  logic        clk = 1'b0;
  logic        rstN, diagEn, fetchLoadEn, busWr, busRd;
  logic [31:0] busWdata, busRdata;
  logic        fifoFull, fifoEmpty, spacingErr;

  wideFifoDiagPort #(.DEPTH(DEPTH), .SPACING(SPACING)) i_wideFifoDiagPort (
    .clk(clk), .rstN(rstN), .diagEn(diagEn), .fetchLoadEn(fetchLoadEn),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .spacingErr(spacingErr)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model built from the requirements
  logic [63:0] q[$];
  bit          mPrimed, mHalf, mWrHalf;
  logic [63:0] mLatch;
  logic [31:0] mLow;

  function automatic bit accessOn();
    return diagEn && !fetchLoadEn;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    q.delete();
    mPrimed = 0; mHalf = 0; mWrHalf = 0;
  endtask

  task automatic doReset();
    rstN = 0; diagEn = 1; fetchLoadEn = 0; busWr = 0; busRd = 0; busWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    modelReset();
    @(negedge clk);
  endtask

  task automatic doWrite(logic [31:0] d);
    bit en = accessOn();
    busWr = 1; busWdata = d;
    @(negedge clk);
    busWr = 0;
    if (en) begin
      if (!mWrHalf) mLow = d;
      else if (q.size() < DEPTH) q.push_back({d, mLow});
      mWrHalf = !mWrHalf;
    end
  endtask

  // Advance model after an accepted read; return expected data and validity
  task automatic modelRead(output logic [31:0] exp, output bit valid);
    valid = mPrimed;
    exp   = mLatch[31:0];
    if (!mPrimed) begin
      if (q.size() != 0) begin mLatch = q.pop_front(); mPrimed = 1; mHalf = 0; end
    end else if (!mHalf) begin
      mLatch[31:0] = mLatch[63:32]; mHalf = 1;
    end else begin
      if (q.size() != 0) begin mLatch = q.pop_front(); mHalf = 0; end
      else mPrimed = 0;
    end
  endtask

  task automatic doRead(string req);
    logic [31:0] got, exp;
    bit valid;
    bit en = accessOn();
    busRd = 1;
    #1 got = busRdata;
    @(negedge clk);
    busRd = 0;
    repeat (SPACING - 1) @(negedge clk);
    if (en) begin
      modelRead(exp, valid);
      if (valid) check(got === exp, req, "read data", {32'h0, got}, {32'h0, exp});
    end
  endtask

  task automatic checkFlags(string req);
    check(fifoEmpty === (q.size() == 0), req, "fifoEmpty", {63'h0, fifoEmpty}, {63'h0, q.size() == 0});
    check(fifoFull === (q.size() == DEPTH), req, "fifoFull", {63'h0, fifoFull}, {63'h0, q.size() == DEPTH});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung, expected run to complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] g1, g2, e;
    bit v;
    void'($urandom(32'd20240611));
    doReset();

    // R8: reset state
    check(fifoEmpty === 1'b1, "R8", "fifoEmpty after reset", {63'h0, fifoEmpty}, 64'h1);
    check(fifoFull === 1'b0, "R8", "fifoFull after reset", {63'h0, fifoFull}, 64'h0);
    check(spacingErr === 1'b0, "R8", "spacingErr after reset", {63'h0, spacingErr}, 64'h0);

    // R2, R4, R5: three entries, priming read, then six halves in order
    for (int i = 0; i < 6; i++) doWrite(32'hA000_0000 + i);
    checkFlags("R2");
    doRead("R4");
    for (int i = 0; i < 6; i++) doRead("R5");
    // R7: FIFO ran dry on last reload; next read is a priming read again
    check(fifoEmpty === 1'b1, "R7", "fifoEmpty after drain", {63'h0, fifoEmpty}, 64'h1);
    doRead("R7");
    doWrite(32'h1111_0001); doWrite(32'h1111_0002);
    doRead("R7");
    doRead("R7"); doRead("R7");

    // R1: gated writes and reads have no effect
    diagEn = 0;
    doWrite(32'hDEAD_0001); doWrite(32'hDEAD_0002);
    check(fifoEmpty === 1'b1, "R1", "write with diagEn=0", {63'h0, fifoEmpty}, 64'h1);
    diagEn = 1; fetchLoadEn = 1;
    doWrite(32'hDEAD_0003); doWrite(32'hDEAD_0004);
    check(fifoEmpty === 1'b1, "R1", "write with fetchLoadEn=1", {63'h0, fifoEmpty}, 64'h1);
    fetchLoadEn = 0;
    doWrite(32'hC0DE_0000); doWrite(32'hC0DE_0001);
    doRead("R1");
    doRead("R1");
    diagEn = 0; doRead("R1"); diagEn = 1;
    doRead("R1");
    check(spacingErr === 1'b0, "R1", "no error from spaced reads", {63'h0, spacingErr}, 64'h0);

    // R3: fill, overfill, then drain every half
    for (int i = 0; i < 2 * DEPTH; i++) doWrite(32'hF000_0000 + i);
    check(fifoFull === 1'b1, "R3", "fifoFull at depth", {63'h0, fifoFull}, 64'h1);
    doWrite(32'hBAD0_0000); doWrite(32'hBAD0_0001);
    check(fifoFull === 1'b1, "R3", "fifoFull after overfill", {63'h0, fifoFull}, 64'h1);
    doRead("R3");
    for (int i = 0; i < 2 * DEPTH; i++) doRead("R3");
    checkFlags("R3");

    // R6: read one clock after a read returns the stale latch and sets the flag
    doWrite(32'h5555_0000); doWrite(32'h5555_0001);
    doWrite(32'h5555_0002); doWrite(32'h5555_0003);
    doRead("R6");
    busRd = 1;
    #1 g1 = busRdata;
    @(negedge clk);
    #1 g2 = busRdata;
    @(negedge clk);
    busRd = 0;
    repeat (SPACING - 1) @(negedge clk);
    modelRead(e, v);
    check(g1 === e, "R6", "first of close pair", {32'h0, g1}, {32'h0, e});
    check(g2 === g1, "R6", "early read is stale", {32'h0, g2}, {32'h0, g1});
    check(spacingErr === 1'b1, "R6", "spacingErr set", {63'h0, spacingErr}, 64'h1);
    doRead("R6");
    doRead("R6");
    check(spacingErr === 1'b1, "R6", "spacingErr sticky", {63'h0, spacingErr}, 64'h1);

    // Random mix: R2, R3, R5, R7 against the model
    doReset();
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 99);
      diagEn      = ($urandom_range(0, 19) != 0);
      fetchLoadEn = ($urandom_range(0, 19) == 0);
      if (r < 55) doWrite($urandom());
      else doRead("R5");
      diagEn = 1; fetchLoadEn = 0;
      checkFlags("R3");
    end
    check(spacingErr === 1'b0, "R6", "no error in spaced random run", {63'h0, spacingErr}, 64'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule